// File: doc/BRIEF.md
# Xon/Xoff Flow-Control Tracker

This block keeps track of software flow control for one UART channel. It compares every received character against two programmable patterns, one for Xon and one for Xoff. It records which of them have been seen. When transmit flow control is on, it stops the transmitter at a character boundary after an Xoff and lets it go again after an Xon.

When the automatic receive mode is on, the receiver's fill logic can ask for an Xon or an Xoff to be sent. The block holds that request until the serializer reports that the flow character has gone out. After that it reports a short wait for the next data character.

All of this is packed into one 8-bit status byte. The host reads it with a one-cycle read strobe, and the read clears the event fields. The serializer, the FIFOs and the register bus sit outside the block.

Top module: `xflow_tracker`

## Requirements
- R1: A received character equal to the Xoff pattern sets status bit 6, and one equal to the Xon pattern sets bit 7. The field [7:6] therefore reads 01 after an Xoff, 10 after an Xon and 11 after both. It holds until a status read, and it updates whatever the enable inputs are.
- R2: A status read (`st_rd` high for one cycle) clears status [7:4] on the next edge. A read never changes [1:0], and it changes [3:2] only as R5 states.
- R3: With `rx_auto_en` high, `xc_done` while a send is pending ORs a bit into status [5:4]: 01 for an Xon sent, 10 for an Xoff sent. The field reads 00 while `rx_auto_en` is low, and it comes back as 00 after the mode is re-enabled.
- R4: With `tx_flow_en` high, a received Xoff moves the flow field [3:2] from 00 to halt pending (01). The next `tx_char_done` moves it to halted (11). `tx_halt` is high exactly while the field is 11.
- R5: A received Xon moves a halted transmitter to re-enabled (10), which drops `tx_halt`. A status read moves 10 to normal (00). An Xon during halt pending returns the field to 00. If a character matches both patterns, the Xoff meaning wins.
- R6: While `tx_flow_en` is low, the flow field is 00, `tx_halt` is low, and received characters do not affect transmission.
- R7: With `rx_auto_en` high, `auto_xoff_req` makes status [1:0] read 10 with `send_xoff` high, and `auto_xon_req` makes it read 11 with `send_xon` high. A new request replaces a pending one. If both requests arrive together, the Xoff request wins.
- R8: After `xc_done`, status [1:0] reads 01 (waiting for data). It returns to 00 on a `bit_tick` that arrives while `txfifo_empty` is low, and it stays at 01 while the FIFO is empty.
- R9: While `rx_auto_en` is low, status [1:0] reads 00, both send requests stay low, and incoming requests are dropped.
- R10: If a status read and a new event arrive in the same cycle, the bits set by that event stay set after the read.
- R11: After reset, the status byte is 00 and `tx_halt`, `send_xon` and `send_xoff` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xon_pat | input | 8 | Xon match pattern |
| xoff_pat | input | 8 | Xoff match pattern |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| tx_char_done | input | 1 | Transmitter finished a character (boundary) |
| bit_tick | input | 1 | One pulse per bit time |
| txfifo_empty | input | 1 | Transmit FIFO is empty |
| tx_flow_en | input | 1 | Transmitter obeys received Xon/Xoff |
| rx_auto_en | input | 1 | Automatic Xon/Xoff sending mode |
| auto_xon_req | input | 1 | Request to send Xon |
| auto_xoff_req | input | 1 | Request to send Xoff |
| xc_done | input | 1 | Serializer finished the requested flow character |
| st_rd | input | 1 | Status read strobe |
| tx_halt | output | 1 | Stop the transmitter |
| send_xon | output | 1 | Xon send pending |
| send_xoff | output | 1 | Xoff send pending |
| status | output | 8 | Packed status byte |

## Verification
The hardest situation to reach is the one where a status read lands in the same cycle as a state change in more than one field. Examples are a read together with a new Xon match while the flow field is re-enabled, or a read together with `xc_done`. Random stimulus seldom lines these up. Directed sequences therefore first walk the flow field through halt pending, halted and re-enabled, and the pending field through request, send and wait. Strobes are then applied together in the chosen cycle. A long random phase runs alongside a behavioural reference model, which covers the remaining overlaps cycle by cycle.

// File: rtl/xft_pkg.sv
package xft_pkg;
    typedef enum logic [1:0] {
        FL_NORMAL    = 2'b00,
        FL_HALT_PEND = 2'b01,
        FL_REENABLED = 2'b10,
        FL_HALTED    = 2'b11
    } flow_e;

    typedef enum logic [1:0] {
        PD_IDLE = 2'b00,
        PD_WAIT = 2'b01,
        PD_XOFF = 2'b10,
        PD_XON  = 2'b11
    } pend_e;

    typedef struct packed {
        logic seen_xon;
        logic seen_xoff;
    } rxdet_st_t;

    typedef struct packed {
        flow_e flow;
    } txflow_st_t;

    typedef struct packed {
        pend_e      pend;
        logic [1:0] sent;
    } sender_st_t;
endpackage

// File: rtl/xft_rxdet.sv
module xft_rxdet
    import xft_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic [CHAR_W-1:0] xon_pat,
    input  logic [CHAR_W-1:0] xoff_pat,
    input  logic              st_rd,
    output logic              hit_xon,
    output logic              hit_xoff,
    output logic [1:0]        seen
);
    rxdet_st_t st_d, st_q;

    always_comb begin
        hit_xon  = rx_valid && (rx_data == xon_pat);
        hit_xoff = rx_valid && (rx_data == xoff_pat);
        st_d = st_q;
        if (st_rd) begin
            st_d = '0;
        end
        if (hit_xon) begin
            st_d.seen_xon = 1'b1;
        end
        if (hit_xoff) begin
            st_d.seen_xoff = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seen = {st_q.seen_xon, st_q.seen_xoff};
endmodule

// File: rtl/xft_txflow.sv
module xft_txflow
    import xft_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       hit_xon,
    input  logic       hit_xoff,
    input  logic       char_done,
    input  logic       st_rd,
    output logic [1:0] flow,
    output logic       halt
);
    txflow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.flow = FL_NORMAL;
        end else begin
            unique case (st_q.flow)
                FL_NORMAL: begin
                    if (hit_xoff) begin
                        st_d.flow = FL_HALT_PEND;
                    end
                end
                FL_HALT_PEND: begin
                    if (hit_xoff) begin
                        st_d.flow = char_done ? FL_HALTED : FL_HALT_PEND;
                    end else if (hit_xon) begin
                        st_d.flow = FL_NORMAL;
                    end else if (char_done) begin
                        st_d.flow = FL_HALTED;
                    end
                end
                FL_HALTED: begin
                    if (hit_xon && !hit_xoff) begin
                        st_d.flow = FL_REENABLED;
                    end
                end
                FL_REENABLED: begin
                    if (hit_xoff) begin
                        st_d.flow = FL_HALT_PEND;
                    end else if (st_rd) begin
                        st_d.flow = FL_NORMAL;
                    end
                end
                default: st_d.flow = FL_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flow: FL_NORMAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign flow = st_q.flow;
    assign halt = (st_q.flow == FL_HALTED);
endmodule

// File: rtl/xft_sender.sv
module xft_sender
    import xft_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       req_xon,
    input  logic       req_xoff,
    input  logic       xc_done,
    input  logic       bit_tick,
    input  logic       fifo_empty,
    input  logic       st_rd,
    output logic [1:0] pend,
    output logic [1:0] sent,
    output logic       send_xon,
    output logic       send_xoff
);
    sender_st_t st_d, st_q;
    logic       pending_q;

    assign pending_q = (st_q.pend == PD_XON) || (st_q.pend == PD_XOFF);

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.pend = PD_IDLE;
            st_d.sent = '0;
        end else begin
            if (st_rd) begin
                st_d.sent = '0;
            end
            if (xc_done && pending_q) begin
                st_d.sent = st_d.sent | ((st_q.pend == PD_XON) ? 2'b01 : 2'b10);
                st_d.pend = PD_WAIT;
            end else if ((st_q.pend == PD_WAIT) && bit_tick && !fifo_empty) begin
                st_d.pend = PD_IDLE;
            end
            if (req_xoff) begin
                st_d.pend = PD_XOFF;
            end else if (req_xon) begin
                st_d.pend = PD_XON;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pend: PD_IDLE, sent: 2'b00};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend      = en ? st_q.pend : 2'b00;
    assign sent      = en ? st_q.sent : 2'b00;
    assign send_xon  = en && (st_q.pend == PD_XON);
    assign send_xoff = en && (st_q.pend == PD_XOFF);
endmodule

// File: rtl/xflow_tracker.sv
module xflow_tracker #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] xon_pat,
    input  logic [CHAR_W-1:0] xoff_pat,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              tx_char_done,
    input  logic              bit_tick,
    input  logic              txfifo_empty,
    input  logic              tx_flow_en,
    input  logic              rx_auto_en,
    input  logic              auto_xon_req,
    input  logic              auto_xoff_req,
    input  logic              xc_done,
    input  logic              st_rd,
    output logic              tx_halt,
    output logic              send_xon,
    output logic              send_xoff,
    output logic [7:0]        status
);
    logic       hit_xon, hit_xoff;
    logic [1:0] seen, flow, pend, sent;

    xft_rxdet #(.CHAR_W(CHAR_W)) u_rxdet (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .xon_pat  (xon_pat),
        .xoff_pat (xoff_pat),
        .st_rd    (st_rd),
        .hit_xon  (hit_xon),
        .hit_xoff (hit_xoff),
        .seen     (seen)
    );

    xft_txflow u_txflow (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_flow_en),
        .hit_xon   (hit_xon),
        .hit_xoff  (hit_xoff),
        .char_done (tx_char_done),
        .st_rd     (st_rd),
        .flow      (flow),
        .halt      (tx_halt)
    );

    xft_sender u_sender (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rx_auto_en),
        .req_xon    (auto_xon_req),
        .req_xoff   (auto_xoff_req),
        .xc_done    (xc_done),
        .bit_tick   (bit_tick),
        .fifo_empty (txfifo_empty),
        .st_rd      (st_rd),
        .pend       (pend),
        .sent       (sent),
        .send_xon   (send_xon),
        .send_xoff  (send_xoff)
    );

    assign status = {seen, sent, flow, pend};
endmodule

// File: rtl/xft_checker.sv
module xft_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       tx_char_done,
    input logic       tx_flow_en,
    input logic       rx_auto_en,
    input logic       st_rd,
    input logic       tx_halt,
    input logic       send_xon,
    input logic       send_xoff,
    input logic [7:0] status
);
    AST_RX_FIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_rd && !rx_valid) |=> (status[7:6] == $past(status[7:6]))); // R1

    AST_HALT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_halt) |-> $past(tx_char_done)); // R4

    AST_REENABLE_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:2] == 2'b10 && $past(status[3:2]) != 2'b10) |-> ($past(status[3:2]) == 2'b11)); // R5

    AST_FLOW_OFF_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_flow_en |=> (status[3:2] == 2'b00 && !tx_halt)); // R6

    AST_SEND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({send_xon, send_xoff})); // R7

    AST_AUTO_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_auto_en |-> (status[5:4] == 2'b00 && status[1:0] == 2'b00 && !send_xon && !send_xoff)); // R9
endmodule

bind xflow_tracker xft_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .tx_char_done (tx_char_done),
    .tx_flow_en   (tx_flow_en),
    .rx_auto_en   (rx_auto_en),
    .st_rd        (st_rd),
    .tx_halt      (tx_halt),
    .send_xon     (send_xon),
    .send_xoff    (send_xoff),
    .status       (status)
);

// File: tb/xflow_tracker_tb.sv
module xflow_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] XON  = 8'h11;
    localparam logic [7:0] XOFF = 8'h13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] xon_pat = XON, xoff_pat = XOFF, rx_data = 8'h00;
    logic       rx_valid = 0, tx_char_done = 0, bit_tick = 0, txfifo_empty = 0;
    logic       tx_flow_en = 0, rx_auto_en = 0, auto_xon_req = 0, auto_xoff_req = 0;
    logic       xc_done = 0, st_rd = 0;
    logic       tx_halt, send_xon, send_xoff;
    logic [7:0] status;

    int n_chk = 0, n_bad = 0;
    bit model_on = 0;
    int m_rx = 0, m_auto = 0, m_flow = 0, m_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xflow_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .xon_pat(xon_pat), .xoff_pat(xoff_pat),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_char_done(tx_char_done),
        .bit_tick(bit_tick), .txfifo_empty(txfifo_empty), .tx_flow_en(tx_flow_en),
        .rx_auto_en(rx_auto_en), .auto_xon_req(auto_xon_req), .auto_xoff_req(auto_xoff_req),
        .xc_done(xc_done), .st_rd(st_rd), .tx_halt(tx_halt), .send_xon(send_xon),
        .send_xoff(send_xoff), .status(status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        bit hx, hf;
        int nrx, nflow, nauto, npend;
        if (!rst_n) begin
            m_rx = 0; m_auto = 0; m_flow = 0; m_pend = 0;
        end else begin
            hx = rx_valid && (rx_data == xon_pat);
            hf = rx_valid && (rx_data == xoff_pat);
            nrx = st_rd ? 0 : m_rx;
            if (hf) nrx = nrx | 1;
            if (hx) nrx = nrx | 2;
            nflow = m_flow;
            if (!tx_flow_en) nflow = 0;
            else if (m_flow == 0) begin
                if (hf) nflow = 1;
            end else if (m_flow == 1) begin
                if (hf) nflow = tx_char_done ? 3 : 1;
                else if (hx) nflow = 0;
                else if (tx_char_done) nflow = 3;
            end else if (m_flow == 3) begin
                if (hx && !hf) nflow = 2;
            end else begin
                if (hf) nflow = 1;
                else if (st_rd) nflow = 0;
            end
            nauto = m_auto; npend = m_pend;
            if (!rx_auto_en) begin
                nauto = 0; npend = 0;
            end else begin
                if (st_rd) nauto = 0;
                if (xc_done && m_pend >= 2) begin
                    nauto = nauto | ((m_pend == 3) ? 1 : 2);
                    npend = 1;
                end else if (m_pend == 1 && bit_tick && !txfifo_empty) npend = 0;
                if (auto_xoff_req) npend = 2;
                else if (auto_xon_req) npend = 3;
            end
            m_rx = nrx; m_flow = nflow; m_auto = nauto; m_pend = npend;
        end
    end

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk("R1 rx field",   int'(status[7:6]), m_rx);
            chk("R3 sent field", int'(status[5:4]), rx_auto_en ? m_auto : 0);
            chk("R4 flow field", int'(status[3:2]), m_flow);
            chk("R7 pend field", int'(status[1:0]), rx_auto_en ? m_pend : 0);
            chk("R4 tx_halt",    int'(tx_halt), (m_flow == 3) ? 1 : 0);
            chk("R7 send_xon",   int'(send_xon), (rx_auto_en && m_pend == 3) ? 1 : 0);
            chk("R7 send_xoff",  int'(send_xoff), (rx_auto_en && m_pend == 2) ? 1 : 0);
        end
    end

    task automatic cyc();
        @(negedge clk);
        #1;
        rx_valid = 0; tx_char_done = 0; bit_tick = 0; auto_xon_req = 0;
        auto_xoff_req = 0; xc_done = 0; st_rd = 0;
    endtask

    task automatic rx(input logic [7:0] c);
        rx_valid = 1; rx_data = c;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 status in reset", int'(status), 0);
        #1 rst_n = 1;
        cyc();
        chk("R11 status after reset", int'(status), 0);
        chk("R11 outputs after reset", int'({tx_halt, send_xon, send_xoff}), 0);
        model_on = 1;
        tx_flow_en = 1; rx_auto_en = 1;
        cyc();
        // halt path
        rx(XOFF); cyc();
        chk("R1 xoff seen", int'(status[7:6]), 1);
        chk("R4 halt pending", int'(status[3:2]), 1);
        chk("R4 no halt yet", int'(tx_halt), 0);
        tx_char_done = 1; cyc();
        chk("R4 halted", int'(status[3:2]), 3);
        chk("R4 tx_halt high", int'(tx_halt), 1);
        rx(XON); cyc();
        chk("R1 both seen", int'(status[7:6]), 3);
        chk("R5 re-enabled", int'(status[3:2]), 2);
        chk("R5 halt released", int'(tx_halt), 0);
        st_rd = 1; cyc();
        chk("R2 read clears rx", int'(status[7:4]), 0);
        chk("R5 read returns normal", int'(status[3:2]), 0);
        // Xon cancels a halt pending
        rx(XOFF); cyc();
        rx(XON); cyc();
        chk("R5 xon cancels pending", int'(status[3:2]), 0);
        // pattern matching both: xoff meaning wins
        xon_pat = 8'h55; xoff_pat = 8'h55;
        rx(8'h55); cyc();
        chk("R5 dual match is xoff", int'(status[3:2]), 1);
        xon_pat = XON; xoff_pat = XOFF;
        rx(XON); cyc();
        st_rd = 1; cyc();
        // flow disabled
        tx_flow_en = 0;
        rx(XOFF); cyc();
        chk("R6 flow stays normal", int'(status[3:2]), 0);
        chk("R1 detect with flow off", int'(status[7:6]), 1);
        tx_char_done = 1; cyc();
        chk("R6 no halt when off", int'(tx_halt), 0);
        tx_flow_en = 1; st_rd = 1; cyc();
        // automatic sending
        auto_xoff_req = 1; cyc();
        chk("R7 xoff pending", int'(status[1:0]), 2);
        chk("R7 send_xoff", int'(send_xoff), 1);
        auto_xon_req = 1; cyc();
        chk("R7 replaced by xon", int'(status[1:0]), 3);
        auto_xon_req = 1; auto_xoff_req = 1; cyc();
        chk("R7 xoff wins", int'(status[1:0]), 2);
        st_rd = 1; cyc();
        chk("R2 read leaves pend", int'(status[1:0]), 2);
        txfifo_empty = 0; xc_done = 1; cyc();
        chk("R8 waiting", int'(status[1:0]), 1);
        chk("R3 xoff logged", int'(status[5:4]), 2);
        txfifo_empty = 1; bit_tick = 1; cyc();
        chk("R8 held while fifo empty", int'(status[1:0]), 1);
        txfifo_empty = 0; bit_tick = 1; cyc();
        chk("R8 back to idle", int'(status[1:0]), 0);
        auto_xon_req = 1; cyc();
        xc_done = 1; cyc();
        chk("R3 both logged", int'(status[5:4]), 3);
        // read coinciding with events
        st_rd = 1; rx(XON); cyc();
        chk("R10 event survives read", int'(status[7:6]), 2);
        chk("R2 sent cleared", int'(status[5:4]), 0);
        auto_xoff_req = 1; cyc();
        st_rd = 1; xc_done = 1; cyc();
        chk("R10 sent survives read", int'(status[5:4]), 2);
        // auto mode disabled
        auto_xon_req = 1; cyc();
        rx_auto_en = 0; cyc();
        chk("R9 pend cleared", int'(status[1:0]), 0);
        chk("R3 sent zero when off", int'(status[5:4]), 0);
        chk("R9 no sends", int'({send_xon, send_xoff}), 0);
        auto_xoff_req = 1; cyc();
        chk("R9 request ignored", int'(status[1:0]), 0);
        rx_auto_en = 1; cyc();
        chk("R3 stays cleared", int'(status[5:4]), 0);
        chk("R9 nothing held", int'(status[1:0]), 0);
        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 2);
            rx_valid      = ($urandom_range(0, 3) == 0);
            rx_data       = (r == 0) ? XON : (r == 1) ? XOFF : 8'h41;
            tx_char_done  = ($urandom_range(0, 5) == 0);
            bit_tick      = ($urandom_range(0, 3) == 0);
            txfifo_empty  = ($urandom_range(0, 2) == 0);
            st_rd         = ($urandom_range(0, 7) == 0);
            auto_xon_req  = ($urandom_range(0, 9) == 0);
            auto_xoff_req = ($urandom_range(0, 9) == 0);
            xc_done       = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 49) == 0) tx_flow_en = ~tx_flow_en;
            if ($urandom_range(0, 49) == 0) rx_auto_en = ~rx_auto_en;
            @(negedge clk);
            #1;
        end
        cyc();
        finish_run();
    end
endmodule